// File: doc/BRIEF.md
# Character-Framed Serial Port with Loopback Fault Injection

This block is a full-duplex asynchronous serial port that sends and receives one character at a time, with no FIFO. The transmit side has a single holding register that feeds a frame shifter. The receive side has a single data register and a set of sticky error flags. Software programs the frame format through a control register: 7 or 8 data bits, 1 or 2 stop bits, and even, odd or no parity. Bit timing comes from an 8-bit reload divider that counts pulses of its own enable input, not bus cycles. The divider produces a tick at 16 times the baud rate, and it stops counting while a halt input is high.

A loopback mode routes the transmit frame internally to the receiver and holds the external transmit pin idle. While loopback is on, three control bits can force faults so that error-handling software can be exercised:
- A parity fault inverts the sent parity bit.
- A framing fault sends the first stop bit low.
- An overrun fault makes the receiver treat its register as occupied.

Registers are reached with single-cycle write and read strobes and a 2-bit address. Address 0 is transmit data on write and receive data on read. Address 1 is control, address 2 is the divider reload and address 3 is status.

Top module: `char_uart`

## Requirements
- R1: After reset, txd is high, control reads 0x01, the divider reads its reset value (15) and status reads 0x02. Status bits are: bit0 receive full, bit1 transmit holding empty, bit2 transmitter busy, bit3 parity error, bit4 framing error, bit5 overrun.
- R2: A character written to address 0 is sent on txd in this order: a low start bit, the data bits LSB first, the optional parity bit, then high stop bits. Each bit lasts 16 ticks and the line idles high.
- R3: Control bit2 enables parity and control bit3 selects odd parity. With even parity the parity bit makes the count of ones over data and parity even; odd parity inverts that bit.
- R4: Control bit0 selects 8 data bits (1) or 7 data bits (0). A received 7-bit character reads back with bit7 = 0.
- R5: Control bit1 selects two stop bits. A character written while another is being sent waits in the holding register, and its start bit begins one tick after the previous frame's last stop bit ends.
- R6: A tick occurs once every (reload + 1) cycles in which baud_en is high, so one bit lasts 16 × (reload + 1) enabled cycles.
- R7: While halt is high, the divider, transmitter and receiver hold their state, and txd does not change. The frame resumes intact after halt falls.
- R8: The receiver starts a character on a high-to-low transition of its input and confirms the start 8 ticks later. If the line is high at that sample, it drops back to idle without receiving anything.
- R9: A received parity bit that does not match sets the parity error flag. A low first stop bit sets the framing error flag.
- R10: If a character completes while receive full is still set, the overrun flag is set and the new character is discarded; the register keeps the older one.
- R11: Control bit4 enables loopback. In loopback the receiver takes the internal transmit frame, and txd stays high.
- R12: Control bits 5 (parity fault), 6 (framing fault) and 7 (overrun fault) take effect only in loopback. Outside loopback, frames are sent and received normally.
- R13: Reading address 0 clears receive full. Reading address 3 clears the three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_en | input | 1 | Count enable for the baud divider |
| halt | input | 1 | Freezes baud timing and both framers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
rdata follows addr in the same cycle, so the bench samples it 1 ns after applying the address at a falling edge. The clear side effect then lands at the next rising edge. Transmission begins at the first tick after the write, and every bit spans exactly 16 × (reload + 1) enabled cycles. For that reason the bench locks onto the observed start-bit falling edge and samples txd half a bit later and then once per bit, and it checks frame spacing and bit length to the exact cycle. Receive results settle at the middle of the first stop bit, two synchroniser cycles later on the external path. The bench therefore reads status only after a full frame plus two bit times, and it never polls status, because polling would clear the flags under test.

// File: rtl/char_uart_pkg.sv
package char_uart_pkg;

    // Framer state shared by the transmitter and the receiver.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } frm_state_t;

    // Control register layout; the first member is the MSB.
    typedef struct packed {
        logic inj_ovr;   // bit7: force overrun (loopback only)
        logic inj_frm;   // bit6: force low stop bit (loopback only)
        logic inj_par;   // bit5: invert parity bit (loopback only)
        logic loop;      // bit4: internal loopback
        logic par_odd;   // bit3: odd parity
        logic par_en;    // bit2: parity present
        logic stop2;     // bit1: two stop bits
        logic len8;      // bit0: 8 data bits (else 7)
    } ctrl_t;

    // Parity bit for a data byte already masked to its length.
    function automatic logic calc_par(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/char_uart_baud.sv
// Baud divider: an 8-bit down counter reloaded from a register.
// It counts only in cycles where en is high and halt is low, and it
// issues a one-cycle tick each time it wraps through zero.
// Assumes: en is a clock enable in the clk domain.
module char_uart_baud #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         halt,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         run;

    assign run  = en && !halt;
    assign tick = run && (cnt == '0);

    // Count down on enabled cycles and reload after zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
endmodule

// File: rtl/char_uart_tx.sv
// Transmit framer with a one-character holding register.
// A frame starts only on a tick, so frames align to the divider.
// Fault injection is honoured only when loopback is set.
// Assumes: tick is a single-cycle pulse; cfg is stable during a frame.
module char_uart_tx
    import char_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  ctrl_t      cfg,
    input  logic       load,
    input  logic [7:0] load_data,
    output logic       line,
    output logic       hold_empty,
    output logic       busy
);
    localparam int TW = $clog2(OSR);

    frm_state_t    st;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic          stop_n;
    logic [7:0]    hold;
    logic [7:0]    sh;
    logic          hold_full;

    logic          bit_end;
    logic [2:0]    last_bit;
    logic [2:0]    nxt;
    logic [7:0]    sh_m;
    logic          f_par;
    logic          f_frm;

    assign bit_end    = tick && (tcnt == TW'(OSR - 1));
    assign last_bit   = cfg.len8 ? 3'd7 : 3'd6;
    assign nxt        = bidx + 3'd1;
    assign sh_m       = cfg.len8 ? sh : {1'b0, sh[6:0]};
    assign f_par      = cfg.loop && cfg.inj_par;
    assign f_frm      = cfg.loop && cfg.inj_frm;
    assign hold_empty = !hold_full;
    assign busy       = (st != S_IDLE);

    // Frame sequencer; a bus write to the holding register wins last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            stop_n    <= 1'b0;
            hold      <= '0;
            sh        <= '0;
            hold_full <= 1'b0;
            line      <= 1'b1;
        end else begin
            if (tick)
                tcnt <= (st == S_IDLE || bit_end) ? '0 : tcnt + 1'b1;
            case (st)
                S_IDLE: if (tick && hold_full) begin
                    sh        <= hold;
                    hold_full <= 1'b0;
                    st        <= S_START;
                    line      <= 1'b0;
                end
                S_START: if (bit_end) begin
                    st   <= S_DATA;
                    bidx <= '0;
                    line <= sh[0];
                end
                S_DATA: if (bit_end) begin
                    if (bidx == last_bit) begin
                        if (cfg.par_en) begin
                            st   <= S_PAR;
                            line <= calc_par(sh_m, cfg.par_odd) ^ f_par;
                        end else begin
                            st     <= S_STOP;
                            stop_n <= 1'b0;
                            line   <= !f_frm;
                        end
                    end else begin
                        bidx <= nxt;
                        line <= sh[nxt];
                    end
                end
                S_PAR: if (bit_end) begin
                    st     <= S_STOP;
                    stop_n <= 1'b0;
                    line   <= !f_frm;
                end
                S_STOP: if (bit_end) begin
                    line <= 1'b1;
                    if (cfg.stop2 && !stop_n)
                        stop_n <= 1'b1;
                    else
                        st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
            if (load) begin
                hold      <= load_data;
                hold_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/char_uart_rx.sv
// Receive framer with a one-character data register and sticky flags.
// A start is taken on a high-to-low transition seen at a tick and is
// confirmed half a bit later. Data, parity and the first stop bit are
// sampled at mid-bit. The character completes at the first stop sample.
// Assumes: line_in is already in the clk domain.
module char_uart_rx
    import char_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  ctrl_t      cfg,
    input  logic       line_in,
    input  logic       clr_data,
    input  logic       clr_err,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       perr,
    output logic       ferr,
    output logic       oerr,
    output logic       done
);
    localparam int TW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    frm_state_t    st;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    sh;
    logic          prev;
    logic          rpar;

    logic          bit_end;
    logic          mid_hit;
    logic [2:0]    last_bit;
    logic          f_ovr;

    assign bit_end  = tick && (tcnt == TW'(OSR - 1));
    assign mid_hit  = tick && (tcnt == TW'(HALF - 1));
    assign last_bit = cfg.len8 ? 3'd7 : 3'd6;
    assign f_ovr    = cfg.loop && cfg.inj_ovr;
    assign done     = bit_end && (st == S_STOP);

    // Frame sampler, register clears, and completion bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            prev    <= 1'b1;
            rpar    <= 1'b0;
            rx_data <= '0;
            rx_full <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            oerr    <= 1'b0;
        end else begin
            if (tick) begin
                prev <= line_in;
                tcnt <= (st == S_IDLE || bit_end || (st == S_START && mid_hit))
                        ? '0 : tcnt + 1'b1;
            end
            if (clr_data)
                rx_full <= 1'b0;
            if (clr_err) begin
                perr <= 1'b0;
                ferr <= 1'b0;
                oerr <= 1'b0;
            end
            case (st)
                S_IDLE: if (tick && prev && !line_in)
                    st <= S_START;
                S_START: if (mid_hit) begin
                    if (!line_in) begin
                        st   <= S_DATA;
                        bidx <= '0;
                        sh   <= '0;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_DATA: if (bit_end) begin
                    sh[bidx] <= line_in;
                    if (bidx == last_bit)
                        st <= cfg.par_en ? S_PAR : S_STOP;
                    else
                        bidx <= bidx + 3'd1;
                end
                S_PAR: if (bit_end) begin
                    rpar <= line_in;
                    st   <= S_STOP;
                end
                S_STOP: if (bit_end) begin
                    st <= S_IDLE;
                    if (!line_in)
                        ferr <= 1'b1;
                    if (cfg.par_en && (rpar != calc_par(sh, cfg.par_odd)))
                        perr <= 1'b1;
                    if (f_ovr || (rx_full && !clr_data)) begin
                        oerr <= 1'b1;
                    end else begin
                        rx_data <= sh;
                        rx_full <= 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/char_uart.sv
// Top level of the character-framed serial port.
// Address map: 0 data (write sends, read takes the received character),
// 1 control, 2 divider reload, 3 status (a read clears the error flags).
// rdata depends only on addr; side effects happen on the rd_en edge.
// Assumes: rxd is asynchronous and is synchronised here; the loopback
// path is internal and needs no synchroniser.
module char_uart
    import char_uart_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int OSR     = 16,
    parameter int DIV_RST = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_en,
    input  logic       halt,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd
);
    localparam logic [7:0]       CTRL_RST = 8'h01;
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             rx_s1, rx_s2;
    logic             tick;
    logic             tx_line, hold_empty, tx_busy;
    logic [7:0]       rx_data;
    logic             rx_full, perr, ferr, oerr, rx_done;
    logic             rx_in;

    // Control and divider register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RST);
            div_q  <= DIV_INIT;
        end else if (wr_en) begin
            if (addr == 2'd1) ctrl_q <= ctrl_t'(wdata);
            if (addr == 2'd2) div_q  <= wdata[DIV_W-1:0];
        end
    end

    // Two-stage synchroniser on the external receive pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rxd;
            rx_s2 <= rx_s1;
        end
    end

    assign rx_in = ctrl_q.loop ? tx_line : rx_s2;
    assign txd   = ctrl_q.loop ? 1'b1 : tx_line;

    char_uart_baud #(.W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(baud_en), .halt(halt),
        .reload(div_q), .tick(tick)
    );

    char_uart_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(ctrl_q),
        .load(wr_en && addr == 2'd0), .load_data(wdata),
        .line(tx_line), .hold_empty(hold_empty), .busy(tx_busy)
    );

    char_uart_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(ctrl_q),
        .line_in(rx_in),
        .clr_data(rd_en && addr == 2'd0), .clr_err(rd_en && addr == 2'd3),
        .rx_data(rx_data), .rx_full(rx_full),
        .perr(perr), .ferr(ferr), .oerr(oerr), .done(rx_done)
    );

    // Read-data selection by address.
    always_comb begin
        case (addr)
            2'd0:    rdata = rx_data;
            2'd1:    rdata = ctrl_q;
            2'd2:    rdata = 8'(div_q);
            default: rdata = {2'b00, oerr, ferr, perr, tx_busy, hold_empty, rx_full};
        endcase
    end
endmodule

// File: rtl/char_uart_chk.sv
// Property checker for char_uart, attached with bind.
// Assumes: it sees the top's ports and selected internal state.
module char_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       txd,
    input logic       rx_full,
    input logic       rx_done,
    input logic       oerr,
    input logic [7:0] rx_data,
    input logic [7:0] ctrl
);
    // R1: first cycle out of reset is idle.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (txd && !rx_full));

    // R7: halt without a register write freezes the line.
    a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> $stable(txd));

    // R10: overrun appears only with an occupied register or a forced fault.
    a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> ($past(rx_full) || ($past(ctrl[4]) && $past(ctrl[7]))));

    // R4: a 7-bit character lands with bit7 clear.
    a_r4_len7_msb: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && !$past(ctrl[0])) |-> !rx_data[7]);

    // R13: a data read with no character arriving empties the register.
    a_r13_data_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && !rx_done) |=> !rx_full);
endmodule

bind char_uart char_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halt(halt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .txd(txd), .rx_full(rx_full), .rx_done(rx_done),
    .oerr(oerr), .rx_data(rx_data), .ctrl(ctrl_q)
);

// File: tb/sim_char_uart.sv
module sim_char_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_en = 1'b1;
    logic       halt = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       txd;
    logic       bench_rx = 1'b1;
    logic       ext_loop = 1'b0;
    logic       en_tog = 1'b0;
    logic       mon_loop = 1'b0;
    int         loop_low = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    wire        rxd_w = ext_loop ? txd : bench_rx;

    always #5 clk = ~clk;

    char_uart u0 (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .halt(halt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rxd(rxd_w), .txd(txd)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) baud_en <= en_tog ? ~baud_en : 1'b1;
    always @(negedge clk) if (mon_loop && txd !== 1'b1) loop_low <= loop_low + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic int frame_len(input logic [7:0] c);
        return 1 + (c[0] ? 8 : 7) + int'(c[2]) + (c[1] ? 2 : 1);
    endfunction

    // Expected line level of frame bit i (R2, R3, R4, R12).
    function automatic logic exp_bit(input logic [7:0] d, input logic [7:0] c, input int i);
        int nd;
        int k;
        logic [7:0] m;
        nd = c[0] ? 8 : 7;
        m  = c[0] ? d : {1'b0, d[6:0]};
        if (i == 0) return 1'b0;
        if (i <= nd) return d[i-1];
        k = i - nd - 1;
        if (c[2]) begin
            if (k == 0) return (^m) ^ c[3] ^ (c[4] & c[5]);
            k--;
        end
        if (k == 0) return !(c[4] & c[6]);
        return 1'b1;
    endfunction

    function automatic logic [7:0] stat(input bit rxf, input bit pe, input bit fe, input bit oe);
        return {2'b00, oe, fe, pe, 1'b0, 1'b1, rxf};
    endfunction

    task automatic wait_fall(output int t);
        int guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        t = cyc;
    endtask

    // Sample txd at each bit centre from the start edge (R2).
    task automatic watch_tx(input logic [7:0] d, input logic [7:0] c, input int b, input string tag);
        int t;
        wait_fall(t);
        repeat (b / 2) @(negedge clk);
        for (int i = 0; i < frame_len(c); i++) begin
            chk(txd === exp_bit(d, c, i), tag, int'(txd), int'(exp_bit(d, c, i)));
            if (i < frame_len(c) - 1) repeat (b) @(negedge clk);
        end
    endtask

    // Drive a frame on rxd from the bench, optionally with bad parity.
    task automatic send_rx(input logic [7:0] d, input logic [7:0] c, input int b, input bit flip);
        int nd;
        nd = c[0] ? 8 : 7;
        for (int i = 0; i < frame_len(c); i++) begin
            @(negedge clk);
            bench_rx = exp_bit(d, c, i) ^ (flip && c[2] && i == nd + 1);
            repeat (b - 1) @(negedge clk);
        end
        @(negedge clk); bench_rx = 1'b1;
        repeat (2 * b) @(negedge clk);
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        logic [7:0] r, c, d;
        int b, dv, t1, t2, n;
        bit ok;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk(txd === 1'b1, "R1 txd", int'(txd), 1);
        bus_rd(2'd3, r); chk(r == 8'h02, "R1 status", r, 8'h02);
        bus_rd(2'd1, r); chk(r == 8'h01, "R1 ctrl", r, 8'h01);
        bus_rd(2'd2, r); chk(r == 8'd15, "R1 divider", r, 15);

        // R12: faults set outside loopback change nothing; R2/R3 frame.
        bus_wr(2'd2, 8'd3); b = 64;
        ext_loop = 1'b1;
        c = 8'hE5;
        bus_wr(2'd1, c);
        bus_wr(2'd0, 8'hA5);
        watch_tx(8'hA5, c, b, "R12 frame");
        repeat (2 * b) @(negedge clk);
        bus_rd(2'd3, r); chk(r == stat(1, 0, 0, 0), "R12 status", r, stat(1, 0, 0, 0));
        bus_rd(2'd0, r); chk(r == 8'hA5, "R12 data", r, 8'hA5);

        // R2 R3 R4 R5: random formats through the external pins.
        for (int k = 0; k < 12; k++) begin
            dv = 1 + int'($urandom_range(2)); b = 16 * (dv + 1);
            c = {4'h0, 4'($urandom_range(15))};
            d = 8'($urandom_range(255));
            bus_wr(2'd2, 8'(dv));
            bus_wr(2'd1, c);
            bus_wr(2'd0, d);
            watch_tx(d, c, b, "R2 R3 R5 frame");
            repeat (2 * b) @(negedge clk);
            bus_rd(2'd3, r); chk(r == stat(1, 0, 0, 0), "R3 status", r, stat(1, 0, 0, 0));
            bus_rd(2'd0, r);
            chk(r == (c[0] ? d : {1'b0, d[6:0]}), "R4 data", r, c[0] ? d : {1'b0, d[6:0]});
        end
        ext_loop = 1'b0;

        // R9 R11 R13: loopback with random forced faults.
        for (int k = 0; k < 30; k++) begin
            dv = 1 + int'($urandom_range(2)); b = 16 * (dv + 1);
            c = {3'($urandom_range(7)), 1'b1, 4'($urandom_range(15))};
            d = 8'($urandom_range(255));
            bus_wr(2'd2, 8'(dv));
            bus_wr(2'd1, c);
            mon_loop = 1'b1;
            bus_wr(2'd0, d);
            repeat ((frame_len(c) + 2) * b) @(negedge clk);
            bus_rd(2'd3, r);
            chk(r == stat(!c[7], c[2] & c[5], c[6], c[7]), "R9 status", r,
                stat(!c[7], c[2] & c[5], c[6], c[7]));
            if (!c[7]) begin
                bus_rd(2'd0, r);
                chk(r == (c[0] ? d : {1'b0, d[6:0]}), "R11 data", r, c[0] ? d : {1'b0, d[6:0]});
            end
            bus_rd(2'd3, r); chk(r == 8'h02, "R13 cleared", r, 8'h02);
        end
        mon_loop = 1'b0;
        chk(loop_low == 0, "R11 txd idle in loopback", loop_low, 0);

        // R10: natural overrun keeps the first character.
        bus_wr(2'd2, 8'd1); b = 32;
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd0, 8'h3C); repeat (12 * b) @(negedge clk);
        bus_wr(2'd0, 8'hC3); repeat (12 * b) @(negedge clk);
        bus_rd(2'd3, r); chk(r == stat(1, 0, 0, 1), "R10 status", r, stat(1, 0, 0, 1));
        bus_rd(2'd0, r); chk(r == 8'h3C, "R10 data kept", r, 8'h3C);
        bus_rd(2'd3, r); chk(r == 8'h02, "R13 after clear", r, 8'h02);

        // R5 R6: back-to-back frames, 8E2, reload 2 -> 48 cycles per bit.
        bus_wr(2'd2, 8'd2); b = 48;
        bus_wr(2'd1, 8'h07);
        bus_wr(2'd0, 8'h55);
        wait_fall(t1);
        bus_wr(2'd0, 8'h0F);
        n = 12 * b + 3;
        while (cyc < t1 + n - 1) @(negedge clk);
        chk(txd === 1'b1, "R5 last stop", int'(txd), 1);
        @(negedge clk);
        chk(txd === 1'b0, "R5 next start", int'(txd), 0);
        repeat (14 * b) @(negedge clk);

        // R6: start-bit length with gated enable and with a larger reload.
        bus_wr(2'd1, 8'h01);
        bus_wr(2'd2, 8'd1);
        en_tog = 1'b1;
        bus_wr(2'd0, 8'hFF);
        wait_fall(t1); t2 = 0;
        while (txd === 1'b0 && t2 < 500) begin @(negedge clk); t2++; end
        chk(t2 == 64, "R6 gated bit", t2, 64);
        repeat (20 * 64) @(negedge clk);
        en_tog = 1'b0;
        bus_wr(2'd2, 8'd4);
        bus_wr(2'd0, 8'hFF);
        wait_fall(t1); t2 = 0;
        while (txd === 1'b0 && t2 < 500) begin @(negedge clk); t2++; end
        chk(t2 == 80, "R6 reload 4", t2, 80);
        repeat (12 * 80) @(negedge clk);

        // R7: halt mid-frame, then the character completes intact.
        bus_wr(2'd2, 8'd2); b = 48;
        ext_loop = 1'b1;
        bus_wr(2'd0, 8'h96);
        wait_fall(t1);
        repeat (3 * b) @(negedge clk);
        halt = 1'b1;
        r = {7'd0, txd}; ok = 1'b1;
        repeat (300) begin @(negedge clk); if (txd !== r[0]) ok = 1'b0; end
        chk(ok, "R7 txd frozen", int'(ok), 1);
        halt = 1'b0;
        repeat (12 * b) @(negedge clk);
        bus_rd(2'd3, r); chk(r == stat(1, 0, 0, 0), "R7 status", r, stat(1, 0, 0, 0));
        bus_rd(2'd0, r); chk(r == 8'h96, "R7 data", r, 8'h96);
        ext_loop = 1'b0;

        // R8: short low pulse ignored; then valid and bad-parity frames.
        bus_wr(2'd2, 8'd3); b = 64;
        bus_wr(2'd1, 8'h05);
        @(negedge clk); bench_rx = 1'b0;
        repeat (12) @(negedge clk); bench_rx = 1'b1;
        repeat (3 * b) @(negedge clk);
        bus_rd(2'd3, r); chk(r == 8'h02, "R8 glitch ignored", r, 8'h02);
        send_rx(8'h4E, 8'h05, b, 1'b0);
        bus_rd(2'd3, r); chk(r == stat(1, 0, 0, 0), "R8 valid start", r, stat(1, 0, 0, 0));
        bus_rd(2'd0, r); chk(r == 8'h4E, "R8 data", r, 8'h4E);
        send_rx(8'hB1, 8'h05, b, 1'b1);
        bus_rd(2'd3, r); chk(r == stat(1, 1, 0, 0), "R9 bad parity", r, stat(1, 1, 0, 0));
        bus_rd(2'd0, r); chk(r == 8'hB1, "R9 data", r, 8'hB1);

        report();
        $finish;
    end
endmodule